// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 32 peripheral sources and presents them to a processor on two lines. The fast line carries every enabled request that software has put in the fast class. The normal line carries all other enabled requests. Software puts each source in a class with one bit per source. It can also hand any source to one of 16 vector slots, where slot 0 ranks highest and slot 15 lowest. Sources that are normal but not claimed by a slot are served through a shared default routine.

A normal-interrupt handler reads one register to get the service address of the highest-ranked active slot. If no slot is active, that register returns the default address. Status words show the raw requests, the active fast sources and the active normal sources. A software-request register can raise any source line without hardware. All registers sit on a simple synchronous bus: a word address, a write strobe, write data, and combinational read data.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register holds zero and both interrupt outputs are low, so every read returns 0.
- R2: A write to word 0x01 sets the enable bits that are 1 in the data. A write to word 0x02 clears the enable bits that are 1 in the data. Reading either word returns the enable mask.
- R3: Word 0x00 reads the registered raw requests, which are hardware inputs OR software requests, whatever the enables and classes are.
- R4: `fast_irq_o` is high when any source is enabled, is requesting, and has its class bit set (word 0x03, bit n for source n, 1 = fast). The output is registered, so it follows an input change one clock edge later.
- R5: Word 0x06 reads the enabled, requesting, fast-class sources as a bit mask.
- R6: `norm_irq_o` is high when any source is enabled, is requesting, and has its class bit clear. A fast-class source never drives it, even when a slot selects that source. It follows an input change one clock edge later.
- R7: Word 0x07 reads the enabled, requesting, normal-class sources as a bit mask.
- R8: Word 0x08 reads the address held in word 0x20+s for the lowest-numbered slot s whose enable bit is set and whose selected source is active in the normal class. If no slot qualifies, it reads the default address held in word 0x09.
- R9: A write to word 0x04 sets software-request bits and a write to word 0x05 clears them. Software requests are ORed with the hardware inputs before masking, and both words read back the software-request mask.
- R10: Word 0x10+s holds the control of slot s: bits 4:0 select the source and bit 8 enables the slot. Both fields read back.
- R11: A source whose enable bit is clear does not affect either output, either active mask, or the vector address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_irq_i | input | 32 | Level requests from peripherals, bit n is source n |
| reg_addr_i | input | 8 | Register word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| fast_irq_o | output | 1 | Combined fast-class request to the processor |
| norm_irq_o | output | 1 | Combined vectored and default-class request to the processor |

## Verification
A change on `hw_irq_i` shows up in the raw and active masks, in the vector address, and on both outputs after exactly one rising edge. The bench checks that an output still holds its old value just before that edge and holds the new value just after it. A register write updates the read-back masks and the vector address after the write edge, but it reaches the two outputs only one edge later. For that reason the bench lets two edges pass after each random configuration and stimulus step before it compares anything against its model. All sampling happens one time unit after a falling edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int ADDR_W        = 8;
    localparam int SLOT_EN_BIT   = 8;
    localparam int SLOT_CTL_BASE = 16;
    localparam int SLOT_ADR_BASE = 32;

    localparam logic [ADDR_W-1:0] A_RAW   = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENSET = 8'h01;
    localparam logic [ADDR_W-1:0] A_ENCLR = 8'h02;
    localparam logic [ADDR_W-1:0] A_CLASS = 8'h03;
    localparam logic [ADDR_W-1:0] A_SWSET = 8'h04;
    localparam logic [ADDR_W-1:0] A_SWCLR = 8'h05;
    localparam logic [ADDR_W-1:0] A_FSTAT = 8'h06;
    localparam logic [ADDR_W-1:0] A_NSTAT = 8'h07;
    localparam logic [ADDR_W-1:0] A_VEC   = 8'h08;
    localparam logic [ADDR_W-1:0] A_DEF   = 8'h09;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int DW    = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DW-1:0]                   wr_data,
    output logic [NSRC-1:0]                 en_q,
    output logic [NSRC-1:0]                 cls_q,
    output logic [NSRC-1:0]                 sw_q,
    output logic [DW-1:0]                   def_q,
    output logic [NSLOT-1:0]                slot_en_q,
    output logic [NSLOT-1:0][$clog2(NSRC)-1:0] slot_src_q,
    output logic [NSLOT-1:0][DW-1:0]        slot_addr_q
);
    localparam int SRC_W = $clog2(NSRC);

    logic [NSRC-1:0] wmask;
    assign wmask = wr_data[NSRC-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            cls_q <= '0;
            sw_q  <= '0;
            def_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_ENSET: en_q  <= en_q | wmask;
                A_ENCLR: en_q  <= en_q & ~wmask;
                A_CLASS: cls_q <= wmask;
                A_SWSET: sw_q  <= sw_q | wmask;
                A_SWCLR: sw_q  <= sw_q & ~wmask;
                A_DEF:   def_q <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(SLOT_CTL_BASE + s);
        localparam logic [ADDR_W-1:0] A_ADR = ADDR_W'(SLOT_ADR_BASE + s);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_en_q[s]   <= 1'b0;
                slot_src_q[s]  <= '0;
                slot_addr_q[s] <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_CTL) begin
                    slot_en_q[s]  <= wr_data[SLOT_EN_BIT];
                    slot_src_q[s] <= wr_data[SRC_W-1:0];
                end
                if (wr_addr == A_ADR) begin
                    slot_addr_q[s] <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/vic_req_stage.sv
module vic_req_stage #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hw_irq,
    input  logic [NSRC-1:0] sw_q,
    input  logic [NSRC-1:0] en_q,
    input  logic [NSRC-1:0] cls_q,
    output logic [NSRC-1:0] req_q,
    output logic [NSRC-1:0] fast_act,
    output logic [NSRC-1:0] norm_act,
    output logic            fast_irq_q,
    output logic            norm_irq_q
);
    logic [NSRC-1:0] req_d;

    assign req_d = hw_irq | sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q      <= '0;
            fast_irq_q <= 1'b0;
            norm_irq_q <= 1'b0;
        end else begin
            req_q      <= req_d;
            fast_irq_q <= |(req_d & en_q & cls_q);
            norm_irq_q <= |(req_d & en_q & ~cls_q);
        end
    end

    assign fast_act = req_q & en_q & cls_q;
    assign norm_act = req_q & en_q & ~cls_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int DW    = 32
) (
    input  logic [NSRC-1:0]                    norm_act,
    input  logic [NSLOT-1:0]                   slot_en_q,
    input  logic [NSLOT-1:0][$clog2(NSRC)-1:0] slot_src_q,
    input  logic [NSLOT-1:0][DW-1:0]           slot_addr_q,
    input  logic [DW-1:0]                      def_q,
    output logic [DW-1:0]                      vec_addr,
    output logic                               vec_valid
);
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [NSLOT-1:0]  hit;
    logic [SLOT_W-1:0] win;

    for (genvar s = 0; s < NSLOT; s++) begin : g_hit
        assign hit[s] = slot_en_q[s] & norm_act[slot_src_q[s]];
    end

    always_comb begin
        vec_valid = 1'b0;
        win       = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (hit[s]) begin
                vec_valid = 1'b1;
                win       = SLOT_W'(s);
            end
        end
        vec_addr = vec_valid ? slot_addr_q[win] : def_q;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   hw_irq_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              fast_irq_o,
    output logic              norm_irq_o
);
    localparam int SRC_W = $clog2(NSRC);

    logic [NSRC-1:0]             en_q, cls_q, sw_q, req_q, fast_act, norm_act;
    logic [DW-1:0]               def_q, vec_addr;
    logic [NSLOT-1:0]            slot_en_q;
    logic [NSLOT-1:0][SRC_W-1:0] slot_src_q;
    logic [NSLOT-1:0][DW-1:0]    slot_addr_q;
    logic                        vec_valid;

    vic_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_we_i),
        .wr_addr     (reg_addr_i),
        .wr_data     (reg_wdata_i),
        .en_q        (en_q),
        .cls_q       (cls_q),
        .sw_q        (sw_q),
        .def_q       (def_q),
        .slot_en_q   (slot_en_q),
        .slot_src_q  (slot_src_q),
        .slot_addr_q (slot_addr_q)
    );

    vic_req_stage #(.NSRC(NSRC)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_irq     (hw_irq_i),
        .sw_q       (sw_q),
        .en_q       (en_q),
        .cls_q      (cls_q),
        .req_q      (req_q),
        .fast_act   (fast_act),
        .norm_act   (norm_act),
        .fast_irq_q (fast_irq_o),
        .norm_irq_q (norm_irq_o)
    );

    vic_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_prio (
        .norm_act    (norm_act),
        .slot_en_q   (slot_en_q),
        .slot_src_q  (slot_src_q),
        .slot_addr_q (slot_addr_q),
        .def_q       (def_q),
        .vec_addr    (vec_addr),
        .vec_valid   (vec_valid)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_RAW:            reg_rdata_o[NSRC-1:0] = req_q;
            A_ENSET, A_ENCLR: reg_rdata_o[NSRC-1:0] = en_q;
            A_CLASS:          reg_rdata_o[NSRC-1:0] = cls_q;
            A_SWSET, A_SWCLR: reg_rdata_o[NSRC-1:0] = sw_q;
            A_FSTAT:          reg_rdata_o[NSRC-1:0] = fast_act;
            A_NSTAT:          reg_rdata_o[NSRC-1:0] = norm_act;
            A_VEC:            reg_rdata_o = vec_addr;
            A_DEF:            reg_rdata_o = def_q;
            default: begin
                for (int s = 0; s < NSLOT; s++) begin
                    if (reg_addr_i == ADDR_W'(SLOT_CTL_BASE + s)) begin
                        reg_rdata_o[SRC_W-1:0]   = slot_src_q[s];
                        reg_rdata_o[SLOT_EN_BIT] = slot_en_q[s];
                    end
                    if (reg_addr_i == ADDR_W'(SLOT_ADR_BASE + s)) begin
                        reg_rdata_o = slot_addr_q[s];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int DW   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fast_irq_o,
    input logic              norm_irq_o,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DW-1:0]     reg_wdata_i,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   cls_q,
    input logic [NSRC-1:0]   sw_q,
    input logic [NSRC-1:0]   fast_act,
    input logic [NSRC-1:0]   norm_act,
    input logic              vec_valid
);
    AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> !fast_irq_o && !norm_irq_o); // R1
    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) reg_we_i && reg_addr_i == A_ENCLR |=> (en_q & $past(reg_wdata_i[NSRC-1:0])) == '0); // R2
    AST_FAST_ON: assert property (@(posedge clk) disable iff (!rst_n) (|fast_act) && $stable(en_q) && $stable(cls_q) |-> fast_irq_o); // R4
    AST_FAST_SRC: assert property (@(posedge clk) disable iff (!rst_n) fast_irq_o && $stable(en_q) && $stable(cls_q) |-> (|fast_act)); // R4
    AST_NORM_ON: assert property (@(posedge clk) disable iff (!rst_n) (|norm_act) && $stable(en_q) && $stable(cls_q) |-> norm_irq_o); // R6
    AST_VEC_NORM: assert property (@(posedge clk) disable iff (!rst_n) vec_valid && $stable(en_q) && $stable(cls_q) |-> norm_irq_o); // R8
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n) reg_we_i && reg_addr_i == A_SWSET |=> (sw_q & $past(reg_wdata_i[NSRC-1:0])) == $past(reg_wdata_i[NSRC-1:0])); // R9
endmodule

bind irq_vector_ctrl vic_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_irq_o  (fast_irq_o),
    .norm_irq_o  (norm_irq_o),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .en_q        (en_q),
    .cls_q       (cls_q),
    .sw_q        (sw_q),
    .fast_act    (fast_act),
    .norm_act    (norm_act),
    .vec_valid   (vec_valid)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
    localparam int NS = 16;
    localparam logic [7:0] RAW = 8'h00, ENS = 8'h01, ENC = 8'h02, CLS = 8'h03,
                           SWS = 8'h04, SWC = 8'h05, FST = 8'h06, NST = 8'h07,
                           VEC = 8'h08, DEF = 8'h09, CTL0 = 8'h10, ADR0 = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m_en = '0, m_cls = '0, m_sw = '0, m_def = '0;
    logic        m_sen [NS];
    logic [4:0]  m_src [NS];
    logic [31:0] m_adr [NS];

    always #2.5 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk (clk), .rst_n (rst_n), .hw_irq_i (hw), .reg_addr_i (addr),
        .reg_we_i (we), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
        .fast_irq_o (fiq), .norm_irq_o (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic set_slot(input int s, input logic en, input logic [4:0] src, input logic [31:0] ad);
        wr(CTL0 + 8'(s), {23'd0, en, 3'd0, src});
        wr(ADR0 + 8'(s), ad);
        m_sen[s] = en; m_src[s] = src; m_adr[s] = ad;
    endtask

    function automatic logic [31:0] e_norm();
        return (hw | m_sw) & m_en & ~m_cls;
    endfunction
    function automatic logic [31:0] e_fast();
        return (hw | m_sw) & m_en & m_cls;
    endfunction
    function automatic logic [31:0] e_vec();
        logic [31:0] nm = e_norm();
        for (int s = 0; s < NS; s++)
            if (m_sen[s] && nm[m_src[s]]) return m_adr[s];
        return m_def;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        chk({tag, " R4 fast_irq"}, {31'd0, fiq}, {31'd0, |e_fast()});
        chk({tag, " R6 norm_irq"}, {31'd0, irq}, {31'd0, |e_norm()});
        rd(RAW, d); chk({tag, " R3 raw"}, d, hw | m_sw);
        rd(FST, d); chk({tag, " R5 fast mask"}, d, e_fast());
        rd(NST, d); chk({tag, " R7 norm mask"}, d, e_norm());
        rd(VEC, d); chk({tag, " R8 vector"}, d, e_vec());
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, r;
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++) begin m_sen[s] = 0; m_src[s] = '0; m_adr[s] = '0; end
        idle(3);
        // R1 reset state
        #1;
        chk("R1 fast_irq at reset", {31'd0, fiq}, 32'd0);
        chk("R1 norm_irq at reset", {31'd0, irq}, 32'd0);
        rd(ENS, d); chk("R1 enable at reset", d, 32'd0);
        rd(CTL0 + 8'd5, d); chk("R1 slot ctl at reset", d, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R2 enable set/clear
        wr(ENS, 32'h0000_F0F0); m_en = 32'h0000_F0F0;
        wr(ENC, 32'h0000_3030); m_en &= ~32'h0000_3030;
        rd(ENC, d); chk("R2 enable w1s/w1c", d, 32'h0000_C0C0);

        // R10 slot control readback
        set_slot(3, 1'b1, 5'd7, 32'h0000_3300);
        rd(CTL0 + 8'd3, d); chk("R10 slot ctl fields", d, 32'h0000_0107);

        // R11 disabled source ignored
        set_slot(0, 1'b1, 5'd2, 32'h0000_1000);
        hw = 32'h0000_0004;
        idle(2);
        chk("R11 disabled source irq", {31'd0, irq}, 32'd0);
        rd(VEC, d); chk("R11 disabled source vector", d, 32'd0);
        rd(RAW, d); chk("R3 raw ignores enable", d, 32'h0000_0004);

        // R8 priority: slots 3 and 9 both active, slot 3 wins
        wr(ENS, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        wr(DEF, 32'hDEF0_0000); m_def = 32'hDEF0_0000;
        set_slot(0, 1'b0, 5'd2, 32'h0000_1000);
        set_slot(9, 1'b1, 5'd11, 32'h0000_9900);
        hw = 32'h0000_0880;
        idle(2);
        rd(VEC, d); chk("R8 lowest slot wins", d, 32'h0000_3300);
        set_slot(3, 1'b0, 5'd7, 32'h0000_3300);
        rd(VEC, d); chk("R8 next slot after disable", d, 32'h0000_9900);
        hw = 32'h0000_0001;
        idle(2);
        rd(VEC, d); chk("R8 default address", d, 32'hDEF0_0000);
        chk("R6 non-vectored drives irq", {31'd0, irq}, 32'd1);

        // R6 fast source excluded from slot and normal line
        wr(CLS, 32'h0000_0800); m_cls = 32'h0000_0800;
        hw = 32'h0000_0800;
        idle(2);
        chk("R6 fast source not on norm", {31'd0, irq}, 32'd0);
        chk("R4 fast source on fast", {31'd0, fiq}, 32'd1);
        rd(VEC, d); chk("R6 fast source not vectored", d, 32'hDEF0_0000);

        // R4/R6 one-edge latency
        hw = 32'h0;
        idle(2);
        @(negedge clk); hw = 32'h0000_0010; #1;
        chk("R6 latency before edge", {31'd0, irq}, 32'd0);
        @(posedge clk); #1;
        chk("R6 latency after edge", {31'd0, irq}, 32'd1);
        @(negedge clk); hw = 32'h0000_0800;
        @(posedge clk); #1;
        chk("R4 latency after edge", {31'd0, fiq}, 32'd1);
        chk("R6 drops after edge", {31'd0, irq}, 32'd0);

        // R9 software requests
        hw = 32'h0;
        wr(SWS, 32'h0000_0081); m_sw = 32'h0000_0081;
        wr(SWC, 32'h0000_0001); m_sw = 32'h0000_0080;
        rd(SWS, d); chk("R9 sw mask", d, 32'h0000_0080);
        idle(1);
        check_all("R9 sw");
        wr(SWC, 32'hFFFF_FFFF); m_sw = '0;

        // Random mixed configuration
        for (int it = 0; it < 300; it++) begin
            r = $urandom; wr(ENS, r); m_en |= r;
            r = $urandom & $urandom; wr(ENC, r); m_en &= ~r;
            r = $urandom & $urandom & $urandom; wr(CLS, r); m_cls = r;
            if (it % 7 == 0) begin r = $urandom; wr(DEF, r); m_def = r; end
            for (int k = 0; k < 2; k++) begin
                int s = int'($urandom % NS);
                set_slot(s, 1'($urandom), 5'($urandom), $urandom);
            end
            if (it % 5 == 0) begin
                r = $urandom & $urandom & $urandom & $urandom;
                wr(SWS, r); m_sw |= r;
                r = $urandom; wr(SWC, r); m_sw &= ~r;
            end
            hw = $urandom & $urandom & $urandom;
            if (it % 4 == 0) hw = $urandom & $urandom & $urandom & $urandom & $urandom;
            idle(2);
            check_all("rand");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule